// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte standard configuration header of a 32-bit PCI target card. The bus-side control logic has already decoded the configuration cycle. It presents the selected dword index, taken from address bits 7:2, together with the active-low byte enables, a write strobe with write data, and a read strobe. The block answers reads with registered data. It applies writes only to the fields that software may change, and only in the enabled byte lanes.

Besides the readable header, the block sends the rest of the card what it needs to decode accesses. It drives the programmed base address of a 256-byte I/O window and of a 4 KB memory window, plus the I/O-decode and memory-decode enable bits from the command register. Both base registers hardwire their low address bits to zero, so software can learn each window size by writing all ones and reading the result back.

Top module: `pcicfg_header`

## Requirements
- R1: After reset, cfg_rdata, io_base and mem_base are zero, io_en and mem_en are 0, and the interrupt line field reads 0x00.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID} and dword 2 reads {CLASS_CODE, REV_ID}. Writes to these dwords change nothing.
- R3: A read strobe in one cycle loads cfg_rdata at that clock edge. While no read is strobed, cfg_rdata holds its value.
- R4: cfg_be_n bit i low enables byte lane i (bits 8i+7:8i). A write changes only the writable bits in enabled lanes.
- R5: Dword 4 is the I/O base register. Bit 0 reads 1 and bits 7:1 read 0. Writing all ones reads back 0xFFFFFF01. io_base drives the programmed address with bits 7:0 zero.
- R6: Dword 5 is the memory base register. Bits 11:0 read 0, and writing all ones reads back 0xFFFFF000. mem_base drives the programmed address.
- R7: Dword 1 bits 1:0 are the writable command bits that drive io_en (bit 0) and mem_en (bit 1). All other command bits and the status half (bits 31:16) read 0.
- R8: Dword 15 bits 7:0 are a writable interrupt line. Bits 15:8 read the fixed interrupt pin value 0x01, and bits 31:16 read 0.
- R9: Every other dword index reads 0, and writes to it change no readable field and no output.
- R10: When a read and a write of the same dword fall in one cycle, the read returns the value from before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx | input | 6 | Dword index of the access (address bits 7:2) |
| cfg_be_n | input | 4 | Active-low byte enables |
| cfg_wr | input | 1 | Write strobe, one cycle per dword |
| cfg_rd | input | 1 | Read strobe, one cycle per dword |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| io_base | output | 32 | Programmed I/O window base |
| mem_base | output | 32 | Programmed memory window base |
| io_en | output | 1 | I/O decode enable (command bit 0) |
| mem_en | output | 1 | Memory decode enable (command bit 1) |

## Verification
A read and a write can fall in the same cycle, and the write may hit the very register being read. The bench provokes this in two ways. It strobes both at once on the command dword, and again on the I/O base register while the register is being sized. It expects the read data to show the value from before the write, and a following plain read to show the new value. It also checks that io_en, mem_en and io_base update on the same edge.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int IDX_W = 6;

    localparam logic [IDX_W-1:0] IDX_ID    = 6'd0;
    localparam logic [IDX_W-1:0] IDX_CMD   = 6'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS = 6'd2;
    localparam logic [IDX_W-1:0] IDX_IOBAR = 6'd4;
    localparam logic [IDX_W-1:0] IDX_MBAR  = 6'd5;
    localparam logic [IDX_W-1:0] IDX_INTR  = 6'd15;

    localparam logic [7:0] INT_PIN_A = 8'h01;

    typedef struct packed {
        logic        io_en;
        logic        mem_en;
        logic [7:0]  int_line;
        logic [31:0] rdata;
    } hdr_state_t;

    // Take byte lane b from new_v when its active-low enable is asserted.
    function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  be_n);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[b*8 +: 8] = be_n[b] ? old_v[b*8 +: 8] : new_v[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pcicfg_bar.sv
module pcicfg_bar #(
    parameter int WIN_LOG2 = 8,
    parameter bit IS_IO    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [3:0]  be_n,
    input  logic [31:0] wdata,
    output logic [31:0] rd_val,
    output logic [31:0] base
);
    import pcicfg_pkg::*;

    localparam logic [31:0] ADDR_MASK = ~((32'd1 << WIN_LOG2) - 32'd1);

    typedef struct packed {
        logic [31:0] addr;
    } bar_state_t;

    bar_state_t st_d, st_q;
    logic [31:0] type_bits;

    generate
        if (IS_IO) begin : g_io
            assign type_bits = 32'h0000_0001;
        end else begin : g_mem
            assign type_bits = 32'h0000_0000;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.addr = merge_lanes(st_q.addr, wdata, be_n) & ADDR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base   = st_q.addr;
    assign rd_val = st_q.addr | type_bits;

endmodule

// File: rtl/pcicfg_rdmux.sv
module pcicfg_rdmux #(
    parameter logic [15:0] VENDOR_ID  = 16'h1B7C,
    parameter logic [15:0] DEVICE_ID  = 16'h0A51,
    parameter logic [23:0] CLASS_CODE = 24'h118000,
    parameter logic [7:0]  REV_ID     = 8'h01
) (
    input  logic [5:0]  idx,
    input  logic        io_en,
    input  logic        mem_en,
    input  logic [7:0]  int_line,
    input  logic [31:0] io_bar,
    input  logic [31:0] mem_bar,
    output logic [31:0] data
);
    import pcicfg_pkg::*;

    always_comb begin
        unique case (idx)
            IDX_ID:    data = {DEVICE_ID, VENDOR_ID};
            IDX_CMD:   data = {16'h0000, 14'd0, mem_en, io_en};
            IDX_CLASS: data = {CLASS_CODE, REV_ID};
            IDX_IOBAR: data = io_bar;
            IDX_MBAR:  data = mem_bar;
            IDX_INTR:  data = {16'h0000, INT_PIN_A, int_line};
            default:   data = 32'h0000_0000;
        endcase
    end

endmodule

// File: rtl/pcicfg_header.sv
module pcicfg_header #(
    parameter logic [15:0] VENDOR_ID    = 16'h1B7C,
    parameter logic [15:0] DEVICE_ID    = 16'h0A51,
    parameter logic [23:0] CLASS_CODE   = 24'h118000,
    parameter logic [7:0]  REV_ID       = 8'h01,
    parameter int          IO_WIN_LOG2  = 8,
    parameter int          MEM_WIN_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  cfg_idx,
    input  logic [3:0]  cfg_be_n,
    input  logic        cfg_wr,
    input  logic        cfg_rd,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [31:0] io_base,
    output logic [31:0] mem_base,
    output logic        io_en,
    output logic        mem_en
);
    import pcicfg_pkg::*;

    hdr_state_t  st_d, st_q;
    logic [31:0] io_bar_rd, mem_bar_rd, mux_data;
    logic        io_hit, mem_hit;

    assign io_hit  = cfg_wr && (cfg_idx == IDX_IOBAR);
    assign mem_hit = cfg_wr && (cfg_idx == IDX_MBAR);

    pcicfg_bar #(.WIN_LOG2(IO_WIN_LOG2), .IS_IO(1'b1)) u_io_bar (
        .clk(clk), .rst_n(rst_n), .wr_hit(io_hit), .be_n(cfg_be_n),
        .wdata(cfg_wdata), .rd_val(io_bar_rd), .base(io_base)
    );

    pcicfg_bar #(.WIN_LOG2(MEM_WIN_LOG2), .IS_IO(1'b0)) u_mem_bar (
        .clk(clk), .rst_n(rst_n), .wr_hit(mem_hit), .be_n(cfg_be_n),
        .wdata(cfg_wdata), .rd_val(mem_bar_rd), .base(mem_base)
    );

    pcicfg_rdmux #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
        .CLASS_CODE(CLASS_CODE), .REV_ID(REV_ID)
    ) u_rdmux (
        .idx(cfg_idx), .io_en(st_q.io_en), .mem_en(st_q.mem_en),
        .int_line(st_q.int_line), .io_bar(io_bar_rd), .mem_bar(mem_bar_rd),
        .data(mux_data)
    );

    always_comb begin
        st_d = st_q;
        // Read samples the pre-write state of this cycle.
        if (cfg_rd) st_d.rdata = mux_data;
        if (cfg_wr && (cfg_idx == IDX_CMD) && !cfg_be_n[0]) begin
            st_d.io_en  = cfg_wdata[0];
            st_d.mem_en = cfg_wdata[1];
        end
        if (cfg_wr && (cfg_idx == IDX_INTR) && !cfg_be_n[0]) begin
            st_d.int_line = cfg_wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata = st_q.rdata;
    assign io_en     = st_q.io_en;
    assign mem_en    = st_q.mem_en;

endmodule

// File: rtl/pcicfg_header_chk.sv
module pcicfg_header_chk #(
    parameter logic [15:0] VENDOR_ID = 16'h1B7C,
    parameter logic [15:0] DEVICE_ID = 16'h0A51
) (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  cfg_idx,
    input logic [3:0]  cfg_be_n,
    input logic        cfg_wr,
    input logic        cfg_rd,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [31:0] io_base,
    input logic [31:0] mem_base,
    input logic        io_en,
    input logic        mem_en
);
    // R3: read data only moves on a read strobe
    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata));

    // R2: identification dword returned one cycle after its read
    p_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_idx == 6'd0) |=> cfg_rdata == {DEVICE_ID, VENDOR_ID});

    // R5: full-width I/O base write lands above the window
    p_io_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_idx == 6'd4 && cfg_be_n == 4'b0000)
        |=> io_base == {$past(cfg_wdata[31:8]), 8'h00});

    // R6: full-width memory base write lands above the window
    p_mem_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_idx == 6'd5 && cfg_be_n == 4'b0000)
        |=> mem_base == {$past(cfg_wdata[31:12]), 12'h000});

    // R7: command write drives the decode enables
    p_cmd_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_idx == 6'd1 && !cfg_be_n[0])
        |=> (io_en == $past(cfg_wdata[0])) && (mem_en == $past(cfg_wdata[1])));

    // R9: enables and bases hold without a write to their dword
    p_cmd_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_idx == 6'd1) |=> $stable({io_en, mem_en}));

    p_bar_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && (cfg_idx == 6'd4 || cfg_idx == 6'd5))
        |=> $stable(io_base) && $stable(mem_base));
endmodule

bind pcicfg_header pcicfg_header_chk #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
) u_chk (.*);

// File: tb/pcicfg_header_bench.sv
`timescale 1ns/1ps
module pcicfg_header_bench;

    localparam logic [15:0] VEN = 16'h1B7C;
    localparam logic [15:0] DEV = 16'h0A51;
    localparam logic [23:0] CLS = 24'h118000;
    localparam logic [7:0]  REV = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [3:0]  cfg_be_n = 4'hF;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, io_base, mem_base;
    logic        io_en, mem_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pcicfg_header #(.VENDOR_ID(VEN), .DEVICE_ID(DEV),
                    .CLASS_CODE(CLS), .REV_ID(REV)) u_pcicfg_header (
        .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_be_n(cfg_be_n),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .io_base(io_base), .mem_base(mem_base),
        .io_en(io_en), .mem_en(mem_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_idx = idx; cfg_be_n = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be_n = 4'hF;
    endtask

    task automatic rd(input logic [5:0] idx, output logic [31:0] d);
        @(negedge clk);
        cfg_idx = idx; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rdata", cfg_rdata, 32'h0);
        chk("R1 io_base", io_base, 32'h0);
        chk("R1 mem_base", mem_base, 32'h0);
        chk("R1 enables", {30'd0, mem_en, io_en}, 32'h0);
        rd(6'd15, v);
        chk("R1 int line", v, 32'h0000_0100);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        wr(6'd0, 4'h0, 32'hFFFF_FFFF);
        wr(6'd2, 4'h0, 32'h0);
        rd(6'd0, v); chk("R2 id dword", v, {DEV, VEN});
        rd(6'd2, v); chk("R2 class dword", v, {CLS, REV});
    endtask

    task automatic t_hold();
        logic [31:0] v;
        rd(6'd0, v);
        cfg_idx = 6'd2;
        repeat (3) @(negedge clk);
        chk("R3 hold without read", cfg_rdata, {DEV, VEN});
    endtask

    task automatic t_io_bar();
        logic [31:0] v;
        wr(6'd4, 4'h0, 32'hFFFF_FFFF);
        rd(6'd4, v); chk("R5 io size probe", v, 32'hFFFF_FF01);
        wr(6'd4, 4'h0, 32'h0000_E0FF);
        rd(6'd4, v); chk("R5 io readback", v, 32'h0000_E001);
        chk("R5 io_base", io_base, 32'h0000_E000);
    endtask

    task automatic t_mem_bar();
        logic [31:0] v;
        wr(6'd5, 4'h0, 32'hFFFF_FFFF);
        rd(6'd5, v); chk("R6 mem size probe", v, 32'hFFFF_F000);
        chk("R6 mem_base", mem_base, 32'hFFFF_F000);
    endtask

    task automatic t_bytes();
        logic [31:0] v;
        wr(6'd5, 4'b1101, 32'h1234_5678);
        rd(6'd5, v); chk("R4 lane 1 only", v, 32'hFFFF_5000);
        wr(6'd15, 4'h0, 32'h0000_0033);
        wr(6'd15, 4'b0001, 32'h0000_00AA);
        rd(6'd15, v); chk("R4 lane 0 masked", v, 32'h0000_0133);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        wr(6'd1, 4'h0, 32'hFFFF_FFFF);
        rd(6'd1, v); chk("R7 cmd/status read", v, 32'h0000_0003);
        chk("R7 enables", {30'd0, mem_en, io_en}, 32'h3);
        wr(6'd1, 4'h0, 32'h0000_0002);
        chk("R7 io off mem on", {30'd0, mem_en, io_en}, 32'h2);
    endtask

    task automatic t_intr();
        logic [31:0] v;
        wr(6'd15, 4'h0, 32'hFFFF_FF0B);
        rd(6'd15, v); chk("R8 line and pin", v, 32'h0000_010B);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(6'd3, 4'h0, 32'hFFFF_FFFF);
        wr(6'd9, 4'h0, 32'hFFFF_FFFF);
        rd(6'd9, v);  chk("R9 dword 9", v, 32'h0);
        rd(6'd3, v);  chk("R9 dword 3", v, 32'h0);
        rd(6'd63, v); chk("R9 dword 63", v, 32'h0);
        chk("R9 io_base kept", io_base, 32'h0000_E000);
        chk("R9 enables kept", {30'd0, mem_en, io_en}, 32'h2);
    endtask

    task automatic t_rw_same();
        logic [31:0] v;
        @(negedge clk);
        cfg_idx = 6'd1; cfg_be_n = 4'h0; cfg_wdata = 32'h1; cfg_wr = 1'b1; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_be_n = 4'hF;
        chk("R10 cmd old value", cfg_rdata, 32'h0000_0002);
        chk("R10 enables updated", {30'd0, mem_en, io_en}, 32'h1);
        rd(6'd1, v); chk("R10 cmd new value", v, 32'h0000_0001);
        @(negedge clk);
        cfg_idx = 6'd4; cfg_be_n = 4'h0; cfg_wdata = 32'hFFFF_FFFF; cfg_wr = 1'b1; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_be_n = 4'hF;
        chk("R10 io bar old value", cfg_rdata, 32'h0000_E001);
        chk("R10 io_base updated", io_base, 32'hFFFF_FF00);
        rd(6'd4, v); chk("R10 io bar new value", v, 32'hFFFF_FF01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre();
    end

    task automatic t_reset_pre();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_hold();
        t_io_bar();
        t_mem_bar();
        t_bytes();
        t_cmd();
        t_intr();
        t_unimpl();
        t_rw_same();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule